// File: doc/BRIEF.md
# PHY Delay Register Access Port

This block lets a host reach a small bank of 8-bit PHY delay settings through one 32-bit control word that it both writes and reads. The host first writes the target PHY address and the byte to store while both request bits are low. It then writes the same word again with a request bit set. The rising edge of that bit starts one transfer to the PHY register bank. When the transfer completes, the block sets an acknowledge bit in the word. The host then clears the request bit, and the block clears the acknowledge, which closes a four-phase handshake.

A read request works the same way. When the acknowledge rises, the addressed PHY byte is in a read-only field of the word. The PHY register bank here is a behavioural model with a configurable access latency. Only the delay-register addresses actually used are populated: 0x00 to 0x08 and 0x0B to 0x0D. Any other address accepts and drops writes, and reads back as zero.

Top module: `phyacc_port`

## Requirements
- R1: After reset the control word reads back as all zeros, and acknowledge (bit 26) is low.
- R2: A host write stores the PHY address in bits [7:0], the write byte in bits [15:8], the write request in bit 24 and the read request in bit 25. All four read back as written.
- R3: A 0-to-1 change of bit 24, with bit 25 low, stores the byte from bits [15:8] into the PHY register at the address in bits [7:0].
- R4: A 0-to-1 change of bit 25 reads the addressed PHY register. Its value is in bits [23:16] by the time bit 26 rises, and it stays there until the next completed read.
- R5: Bit 26 rises no later than ACK_LATENCY+2 clock cycles after the host write that set the request bit.
- R6: Bit 26 stays high while either request bit is high. It falls in the cycle after the control register shows both request bits low.
- R7: A request edge that arrives while a transfer is still under way is ignored. It starts no second transfer and does not change bits [23:16].
- R8: If the read request is high when a write request edge occurs, including both bits set in a single host write, the transfer is a read only and the PHY register is not modified.
- R9: A write to an unpopulated PHY address (anything other than 0x00–0x08 and 0x0B–0x0D) is still acknowledged but stores nothing. A read of such an address returns zero.
- R10: A host write with both request bits low starts no transfer, so the acknowledge stays low and the PHY registers keep their values.
- R11: Bits [23:16] and bit 26 ignore host writes. Bits [31:27] always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Host write enable for the control word |
| ctl_wdata | input | 32 | Control word value written by the host |
| ctl_rdata | output | 32 | Current control word: address, write byte, read byte, requests, acknowledge |

## Verification
The assertions check the handshake timing on every cycle. They confirm that the acknowledge arrives within its latency bound, stays high while a request is held, and drops one cycle after both requests clear. They also confirm that the register model is never restarted mid-transfer, that unpopulated reads return zero, and that the control fields capture host writes. The stored PHY contents can only be shown by the bench scenarios, which read values back after writes. The same applies to the read-only treatment of a write edge that arrives with the read request high, the discarded edge during a busy transfer, and the protected read-data and acknowledge fields.

// File: rtl/phyacc_pkg.sv
// Package: shared field positions, handshake state type and the populated
// address map of the PHY delay register bank.
package phyacc_pkg;

    localparam int ADDR_W      = 8;
    localparam int DATA_W      = 8;
    localparam int WORD_W      = 32;
    localparam int F_ADDR_LSB  = 0;
    localparam int F_WDAT_LSB  = 8;
    localparam int F_RDAT_LSB  = 16;
    localparam int B_WR_REQ    = 24;
    localparam int B_RD_REQ    = 25;
    localparam int B_ACK       = 26;

    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_BUSY = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_t;

    // True for the delay-register addresses that exist in the PHY bank.
    function automatic logic slot_populated(input logic [ADDR_W-1:0] a);
        return (a <= 8'h08) || ((a >= 8'h0B) && (a <= 8'h0D));
    endfunction

endpackage

// File: rtl/phyacc_ctlreg.sv
// Module: holds the host-writable fields of the control word.
// Assumes: the host writes the whole word at once; read-only fields are
// sourced elsewhere and the bits carrying them are dropped here.
module phyacc_ctlreg
    import phyacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wbyte_q,
    output logic              wr_req_q,
    output logic              rd_req_q
);

    logic unused_bits;
    assign unused_bits = ^{wdata[WORD_W-1:B_ACK], wdata[F_RDAT_LSB+DATA_W-1:F_RDAT_LSB]};

    // Capture address, write byte and both request bits on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            wbyte_q  <= '0;
            wr_req_q <= 1'b0;
            rd_req_q <= 1'b0;
        end else if (wr_en) begin
            addr_q   <= wdata[F_ADDR_LSB +: ADDR_W];
            wbyte_q  <= wdata[F_WDAT_LSB +: DATA_W];
            wr_req_q <= wdata[B_WR_REQ];
            rd_req_q <= wdata[B_RD_REQ];
        end
    end

    AST_FIELDS_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (addr_q == $past(wdata[F_ADDR_LSB +: ADDR_W])) &&
                  (wbyte_q == $past(wdata[F_WDAT_LSB +: DATA_W])) &&
                  (wr_req_q == $past(wdata[B_WR_REQ]))); // R2

endmodule

// File: rtl/phyacc_hs_fsm.sv
// Module: four-phase handshake controller.
// Finds rising edges of the request bits while idle, launches one PHY access,
// raises the acknowledge when the access finishes and clears it once both
// request bits are low. Assumes the PHY model accepts a start only when idle.
module phyacc_hs_fsm
    import phyacc_pkg::*;
#(
    parameter int ACK_LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              rd_req,
    input  logic              phy_done,
    input  logic [DATA_W-1:0] phy_rbyte,
    output logic              phy_start,
    output logic              phy_start_wr,
    output logic              ack_q,
    output logic [DATA_W-1:0] rbyte_q
);

    localparam int BC_W = $clog2(ACK_LATENCY + 2);

    hs_state_t       state_q;
    logic            prev_wr_q;
    logic            prev_rd_q;
    logic            op_wr_q;
    logic [BC_W-1:0] busy_cnt_q;
    logic            wr_rise;
    logic            rd_rise;

    assign wr_rise      = wr_req & ~prev_wr_q;
    assign rd_rise      = rd_req & ~prev_rd_q;
    // A read request that is high at the edge makes the access read-only.
    assign phy_start    = (state_q == HS_IDLE) & (wr_rise | rd_rise);
    assign phy_start_wr = ~rd_req;

    // Remember the request levels of the previous cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_wr_q <= 1'b0;
            prev_rd_q <= 1'b0;
        end else begin
            prev_wr_q <= wr_req;
            prev_rd_q <= rd_req;
        end
    end

    // Handshake state, acknowledge and read-byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HS_IDLE;
            ack_q   <= 1'b0;
            op_wr_q <= 1'b0;
            rbyte_q <= '0;
        end else begin
            unique case (state_q)
                HS_IDLE: begin
                    if (phy_start) begin
                        state_q <= HS_BUSY;
                        op_wr_q <= phy_start_wr;
                    end
                end
                HS_BUSY: begin
                    if (phy_done) begin
                        state_q <= HS_HOLD;
                        ack_q   <= 1'b1;
                        if (!op_wr_q) begin
                            rbyte_q <= phy_rbyte;
                        end
                    end
                end
                HS_HOLD: begin
                    if (!wr_req && !rd_req) begin
                        state_q <= HS_IDLE;
                        ack_q   <= 1'b0;
                    end
                end
                default: begin
                    state_q <= HS_IDLE;
                    ack_q   <= 1'b0;
                end
            endcase
        end
    end

    // Count cycles spent waiting for the PHY, for the latency bound check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_cnt_q <= '0;
        end else if (state_q != HS_BUSY) begin
            busy_cnt_q <= '0;
        end else if (busy_cnt_q != {BC_W{1'b1}}) begin
            busy_cnt_q <= busy_cnt_q + 1'b1;
        end
    end

    AST_ACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HS_BUSY) |-> (busy_cnt_q <= BC_W'(ACK_LATENCY))); // R5

    AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && (wr_req || rd_req)) |=> ack_q); // R6

    AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_q && !wr_req && !rd_req) |=> !ack_q); // R6

    AST_NO_START_WHEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> !phy_start); // R7

endmodule

// File: rtl/phyacc_phy_model.sv
// Module: behavioural PHY delay register bank with fixed access latency.
// A start latches address, byte and direction; after ACCESS_LATENCY cycles a
// one-cycle done pulse is produced. Only populated slots keep written data;
// all other addresses read as zero. Assumes start never arrives while busy.
module phyacc_phy_model
    import phyacc_pkg::*;
#(
    parameter int NUM_SLOTS      = 16,
    parameter int ACCESS_LATENCY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wbyte,
    output logic              done_q,
    output logic [DATA_W-1:0] rbyte_q
);

    localparam int IDX_W = $clog2(NUM_SLOTS);
    localparam int CNT_W = $clog2(ACCESS_LATENCY + 1);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_byte_q;
    logic              lat_wr_q;
    logic              finish;
    logic              commit;
    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic [DATA_W-1:0] rd_mux;

    assign finish = busy_q && (cnt_q == CNT_W'(ACCESS_LATENCY - 1));
    assign commit = finish && lat_wr_q;

    // One register per slot; unpopulated slots are tied to zero.
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        localparam logic POP = slot_populated(ADDR_W'(i));
        if (POP) begin : g_pop
            logic [DATA_W-1:0] val_q;
            // Store the latched byte when a write to this slot completes.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    val_q <= '0;
                end else if (commit && (lat_addr_q == ADDR_W'(i))) begin
                    val_q <= lat_byte_q;
                end
            end
            assign slot_q[i] = val_q;
        end else begin : g_empty
            assign slot_q[i] = '0;
        end
    end

    // Select the addressed slot; out-of-range addresses read zero.
    always_comb begin
        rd_mux = '0;
        if (lat_addr_q < ADDR_W'(NUM_SLOTS)) begin
            rd_mux = slot_q[lat_addr_q[IDX_W-1:0]];
        end
    end

    // Access sequencing: latch on start, count latency, pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            lat_addr_q <= '0;
            lat_byte_q <= '0;
            lat_wr_q   <= 1'b0;
            done_q     <= 1'b0;
            rbyte_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (start && !busy_q) begin
                busy_q     <= 1'b1;
                cnt_q      <= '0;
                lat_addr_q <= addr;
                lat_byte_q <= wbyte;
                lat_wr_q   <= start_wr;
            end else if (busy_q) begin
                if (finish) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    rbyte_q <= rd_mux;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> !start); // R7

    AST_UNPOP_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !lat_wr_q && !slot_populated(lat_addr_q)) |-> (rbyte_q == '0)); // R9

endmodule

// File: rtl/phyacc_port.sv
// Module: top of the PHY register access port.
// Joins the control word register, the handshake controller and the PHY
// register bank model, and assembles the read-back view of the word.
// Assumes a single host that follows the four-phase protocol.
module phyacc_port
    import phyacc_pkg::*;
#(
    parameter int ACK_LATENCY = 4,
    parameter int NUM_SLOTS   = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr_en,
    input  logic [31:0] ctl_wdata,
    output logic [31:0] ctl_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wbyte_q;
    logic              wr_req_q;
    logic              rd_req_q;
    logic              phy_start;
    logic              phy_start_wr;
    logic              phy_done;
    logic [DATA_W-1:0] phy_rbyte;
    logic              ack_q;
    logic [DATA_W-1:0] rbyte_q;

    phyacc_ctlreg u_ctlreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctl_wr_en),
        .wdata    (ctl_wdata),
        .addr_q   (addr_q),
        .wbyte_q  (wbyte_q),
        .wr_req_q (wr_req_q),
        .rd_req_q (rd_req_q)
    );

    phyacc_hs_fsm #(
        .ACK_LATENCY (ACK_LATENCY)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req_q),
        .rd_req       (rd_req_q),
        .phy_done     (phy_done),
        .phy_rbyte    (phy_rbyte),
        .phy_start    (phy_start),
        .phy_start_wr (phy_start_wr),
        .ack_q        (ack_q),
        .rbyte_q      (rbyte_q)
    );

    phyacc_phy_model #(
        .NUM_SLOTS      (NUM_SLOTS),
        .ACCESS_LATENCY (ACK_LATENCY)
    ) u_phy (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (phy_start),
        .start_wr (phy_start_wr),
        .addr     (addr_q),
        .wbyte    (wbyte_q),
        .done_q   (phy_done),
        .rbyte_q  (phy_rbyte)
    );

    // Read-back view: upper bits zero, then ack, requests, read byte, write byte, address.
    assign ctl_rdata = {5'b0, ack_q, rd_req_q, wr_req_q, rbyte_q, wbyte_q, addr_q};

    AST_ACK_NEEDS_REQ_HISTORY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> (wr_req_q || rd_req_q || $past(wr_req_q || rd_req_q))); // R6

endmodule

// File: tb/phyacc_port_tb_top.sv
// Directed bench for the PHY register access port. One task per scenario.
module phyacc_port_tb_top;

    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr_en = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] ctl_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    phyacc_port #(.ACK_LATENCY(LAT), .NUM_SLOTS(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr_en (ctl_wr_en),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] w);
        @(negedge clk);
        ctl_wr_en = 1'b1;
        ctl_wdata = w;
        @(negedge clk);
        ctl_wr_en = 1'b0;
    endtask

    task automatic wait_ack(output int n);
        n = 0;
        for (int k = 0; k < 50; k++) begin
            if (ctl_rdata[26]) break;
            @(negedge clk);
            n++;
        end
    endtask

    function automatic logic [31:0] mkw(input logic [7:0] a, input logic [7:0] d, input bit wr, input bit rd);
        return {6'b0, rd, wr, 8'h00, d, a};
    endfunction

    task automatic close_hs(input logic [31:0] w);
        host_write(w);
        @(negedge clk);
        chk(ctl_rdata[26] == 1'b0, "R6 ack falls after requests clear", {31'b0, ctl_rdata[26]}, 32'd0);
    endtask

    task automatic phy_write(input logic [7:0] a, input logic [7:0] d);
        int n;
        host_write(mkw(a, d, 1'b0, 1'b0));
        host_write(mkw(a, d, 1'b1, 1'b0));
        wait_ack(n);
        chk(ctl_rdata[26] && n <= LAT + 2, "R5 write ack latency", n, LAT + 2);
        close_hs(mkw(a, d, 1'b0, 1'b0));
    endtask

    task automatic phy_read(input logic [7:0] a, output logic [7:0] d);
        int n;
        host_write(mkw(a, 8'h00, 1'b0, 1'b0));
        host_write(mkw(a, 8'h00, 1'b0, 1'b1));
        wait_ack(n);
        chk(ctl_rdata[26] && n <= LAT + 2, "R5 read ack latency", n, LAT + 2);
        d = ctl_rdata[23:16];
        close_hs(mkw(a, 8'h00, 1'b0, 1'b0));
    endtask

    task automatic t_reset();
        chk(ctl_rdata == 32'h0, "R1 reset word", ctl_rdata, 32'h0);
    endtask

    task automatic t_fields_no_req();
        logic [7:0] d;
        host_write(32'h0000_A505);
        chk(ctl_rdata == 32'h0000_A505, "R2 field readback", ctl_rdata, 32'h0000_A505);
        repeat (10) @(negedge clk);
        chk(ctl_rdata[26] == 1'b0, "R10 no ack without request", ctl_rdata, 32'h0000_A505);
        phy_read(8'h05, d);
        chk(d == 8'h00, "R10 register untouched", d, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] d;
        phy_write(8'h00, 8'h3C);
        phy_write(8'h08, 8'hC3);
        phy_write(8'h0B, 8'h5A);
        phy_write(8'h0D, 8'hE1);
        phy_read(8'h00, d); chk(d == 8'h3C, "R3 R4 addr 00", d, 8'h3C);
        phy_read(8'h08, d); chk(d == 8'hC3, "R3 R4 addr 08", d, 8'hC3);
        phy_read(8'h0D, d); chk(d == 8'hE1, "R3 R4 addr 0D", d, 8'hE1);
        phy_read(8'h0B, d); chk(d == 8'h5A, "R3 R4 addr 0B", d, 8'h5A);
    endtask

    task automatic t_hold();
        int n;
        host_write(mkw(8'h01, 8'h77, 1'b0, 1'b0));
        host_write(mkw(8'h01, 8'h77, 1'b1, 1'b0));
        wait_ack(n);
        repeat (8) @(negedge clk);
        chk(ctl_rdata[26] == 1'b1, "R6 ack held while request high", ctl_rdata, 32'h0400_0000);
        close_hs(mkw(8'h01, 8'h77, 1'b0, 1'b0));
    endtask

    task automatic t_read_only_fields();
        logic [7:0] prev;
        logic [31:0] exp;
        prev = ctl_rdata[23:16];
        host_write(32'hFCFF_0003);
        exp = {16'h0, prev, 8'h00, 8'h03} | 32'h0000_0000;
        chk(ctl_rdata == exp, "R11 read-only bits ignore host", ctl_rdata, exp);
        host_write(32'h0);
    endtask

    task automatic t_busy_edge();
        int n;
        logic [7:0] d;
        phy_read(8'h0B, d);
        host_write(mkw(8'h0C, 8'h99, 1'b0, 1'b0));
        host_write(mkw(8'h0C, 8'h99, 1'b1, 1'b0));
        host_write(mkw(8'h0C, 8'h99, 1'b1, 1'b1));
        wait_ack(n);
        chk(ctl_rdata[23:16] == 8'h5A, "R7 edge during transfer ignored", ctl_rdata[23:16], 8'h5A);
        close_hs(mkw(8'h0C, 8'h99, 1'b0, 1'b0));
        repeat (10) @(negedge clk);
        chk(ctl_rdata[26] == 1'b0, "R7 no second transfer", ctl_rdata, 32'h0);
        phy_read(8'h0C, d);
        chk(d == 8'h99, "R7 first write completed", d, 8'h99);
    endtask

    task automatic t_both();
        int n;
        logic [7:0] d;
        phy_write(8'h02, 8'h11);
        host_write(mkw(8'h02, 8'hEE, 1'b0, 1'b0));
        host_write(mkw(8'h02, 8'hEE, 1'b1, 1'b1));
        wait_ack(n);
        chk(ctl_rdata[26] && ctl_rdata[23:16] == 8'h11, "R8 both requests read only", ctl_rdata[23:16], 8'h11);
        close_hs(mkw(8'h02, 8'hEE, 1'b0, 1'b0));
        phy_read(8'h02, d);
        chk(d == 8'h11, "R8 register not written", d, 8'h11);
    endtask

    task automatic t_unpopulated();
        logic [7:0] d;
        phy_write(8'h09, 8'h77);
        phy_write(8'h0E, 8'h66);
        phy_write(8'h40, 8'h55);
        phy_read(8'h09, d); chk(d == 8'h00, "R9 addr 09 reads zero", d, 8'h00);
        phy_read(8'h0E, d); chk(d == 8'h00, "R9 addr 0E reads zero", d, 8'h00);
        phy_read(8'h40, d); chk(d == 8'h00, "R9 addr 40 reads zero", d, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields_no_req();
        t_write_read();
        t_hold();
        t_read_only_fields();
        t_busy_edge();
        t_both();
        t_unpopulated();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule